// File: doc/BRIEF.md
# Single-Wire Slave Network Command Layer

This block sits above the slot-timing front end of a single-wire slave. It runs the addressing phase that follows every bus reset and presence sequence. The front end hands it three kinds of event, each a one-cycle strobe: a received write-slot bit, a read-slot request, and a bus reset. In return, the block presents on `txBit` the value to return in the next read slot.

After a bus reset, the block collects a command byte. It then takes one of several paths:
- stream its 64-bit identity to the master;
- compare an identity that the master sends;
- take part in the bit-by-bit search arbitration, either always or only when a selectable condition holds;
- select itself with no identity transfer at all.

Once selected, it raises `selected`, which hands the bus to the function layer. The identity is a parameter.

The conditional search evaluates a 5-bit selector, `condSel`, against a vector of 32 condition inputs, `evtIn`. The device joins the search only if the chosen condition is true at the moment the command byte completes. Until the first bus reset after power-up, the block is deselected and stays silent.

Top module: `swr_rom_layer`

## Requirements
- R1: After `rstN` is released, `selected` is 0 and `txBit` is 1. Bits arriving before the first `busReset` are ignored, so a skip command sent then leaves `selected` at 0.
- R2: A `busReset` strobe at any point abandons the command in progress. From the next cycle `selected` is 0, and the following eight received bits are taken as a fresh command byte.
- R3: Command bytes arrive least significant bit first. Code CCh raises `selected` in the cycle after its eighth bit, with no identity transfer.
- R4: Under code 33h, 64 read slots return identity bits 0 through 63 in that order. `selected` rises after the 64th slot.
- R5: Under code 55h, the master sends 64 bits, bit 0 first. `selected` rises after the last bit only if every bit equals the identity. On the first mismatch the device goes quiet until the next `busReset`.
- R6: Under code F0h, for each identity bit in turn (bit 0 first), the device presents the bit in one read slot and its complement in the next. It then reads one bit from the master. After 64 matching rounds, `selected` rises.
- R7: During a search, a master bit that differs from the device's bit drops the device out. From then on every read slot returns 1 and `selected` stays 0 until the next `busReset`.
- R8: Code ECh behaves exactly like F0h when the condition is true at command completion. Otherwise the device ignores the search: every read slot returns 1 and `selected` stays 0.
- R9: Any other command code leaves the device deselected, with `txBit` at 1, until the next `busReset`.
- R10: `txBit` is 1 whenever the block is not presenting an identity bit or its complement. This covers command reception, match, idle and the selected state.
- R11: The condition used by R8 is `evtIn[condSel]`, where `condSel` is read as an unsigned index from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| busReset | input | 1 | One-cycle strobe: bus reset/presence detected by the front end |
| rxValid | input | 1 | One-cycle strobe: a write slot has been received |
| rxBit | input | 1 | Bit value of the received write slot, valid with `rxValid` |
| txReq | input | 1 | One-cycle strobe: the current `txBit` has been returned in a read slot |
| condSel | input | 5 | Condition selector for the conditional search |
| evtIn | input | 32 | Condition inputs indexed by `condSel` |
| txBit | output | 1 | Value to return in the next read slot (1 = line released) |
| selected | output | 1 | Device addressed; the function layer owns the bus |

## Verification
A wrong bit counter or search phase shows on `txBit` in the very next read slot. The value becomes a neighbouring identity bit, or a bit where its complement belongs, so a search or identity read exposes it within one slot. A state that fails to drop out on a mismatch, or that mis-decodes a command byte, shows as a non-released `txBit` in the next read slot. It also shows as a wrong `selected` value once the 64th bit or the eighth command bit has been taken. A lost bus reset shows within the following command byte, because the skip code then fails to select.

// File: rtl/swr_pkg.sv
package swr_pkg;

  localparam int CmdBits = 8;

  localparam logic [CmdBits-1:0] CodeReadId     = 8'h33;
  localparam logic [CmdBits-1:0] CodeMatchId    = 8'h55;
  localparam logic [CmdBits-1:0] CodeSearch     = 8'hF0;
  localparam logic [CmdBits-1:0] CodeCondSearch = 8'hEC;
  localparam logic [CmdBits-1:0] CodeSkip       = 8'hCC;

  typedef enum logic [2:0] {
    StQuiet,
    StCmd,
    StReadId,
    StMatch,
    StSearch,
    StSel
  } romState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic phClr;
    logic phInc;
    logic cmdShift;
  } dpStrobe_t;

endpackage

// File: rtl/swr_dpath.sv
module swr_dpath
  import swr_pkg::*;
#(
  parameter int IdBits = 64,
  parameter logic [IdBits-1:0] IdCode = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  romState_t          state,
  input  logic               rxBit,
  output logic [CmdBits-1:0] cmdNext,
  output logic               cmdLast,
  output logic               idBit,
  output logic               idLast,
  output logic [1:0]         phase,
  output logic               txBit
);

  localparam int CntW = $clog2(IdBits);

  logic [CntW-1:0]    bitCnt;
  logic [CmdBits-1:0] cmdSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.cntClr) begin
      bitCnt <= '0;
    end else if (strb.cntInc) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 2'd0;
    end else if (strb.phClr) begin
      phase <= 2'd0;
    end else if (strb.phInc) begin
      phase <= phase + 2'd1;
    end
  end

  // Command byte arrives least significant bit first: shift right.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSr <= '0;
    end else if (strb.cmdShift) begin
      cmdSr <= cmdNext;
    end
  end

  assign cmdNext = {rxBit, cmdSr[CmdBits-1:1]};
  assign cmdLast = (bitCnt == CntW'(CmdBits - 1));
  assign idBit   = IdCode[bitCnt];
  assign idLast  = (bitCnt == CntW'(IdBits - 1));

  always_comb begin
    txBit = 1'b1;
    case (state)
      StReadId: txBit = idBit;
      StSearch: begin
        if (phase == 2'd0) begin
          txBit = idBit;
        end else if (phase == 2'd1) begin
          txBit = ~idBit;
        end
      end
      default: txBit = 1'b1;
    endcase
  end

  // R6
  cmpl_follows_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == StSearch && phase == 2'd1 && $past(state == StSearch && phase == 2'd0))
      |-> (txBit != $past(txBit)));

  // R6
  round_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == StSearch && phase == 2'd0 && $past(state == StSearch && phase == 2'd2))
      |-> (bitCnt == $past(bitCnt) + 1'b1));

endmodule

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               rxValid,
  input  logic               rxBit,
  input  logic               txReq,
  input  logic               condMet,
  input  logic [CmdBits-1:0] cmdNext,
  input  logic               cmdLast,
  input  logic               idBit,
  input  logic               idLast,
  input  logic [1:0]         phase,
  output romState_t          state,
  output dpStrobe_t          strb,
  output logic               selected
);

  romState_t stNext;

  always_comb begin
    stNext = state;
    strb   = '0;
    if (busReset) begin
      stNext      = StCmd;
      strb.cntClr = 1'b1;
      strb.phClr  = 1'b1;
    end else begin
      case (state)
        StCmd: begin
          if (rxValid) begin
            strb.cmdShift = 1'b1;
            if (cmdLast) begin
              strb.cntClr = 1'b1;
              strb.phClr  = 1'b1;
              case (cmdNext)
                CodeReadId:     stNext = StReadId;
                CodeMatchId:    stNext = StMatch;
                CodeSearch:     stNext = StSearch;
                CodeCondSearch: stNext = condMet ? StSearch : StQuiet;
                CodeSkip:       stNext = StSel;
                default:        stNext = StQuiet;
              endcase
            end else begin
              strb.cntInc = 1'b1;
            end
          end
        end
        StReadId: begin
          if (txReq) begin
            if (idLast) begin
              stNext = StSel;
            end else begin
              strb.cntInc = 1'b1;
            end
          end
        end
        StMatch: begin
          if (rxValid) begin
            if (rxBit != idBit) begin
              stNext = StQuiet;
            end else if (idLast) begin
              stNext = StSel;
            end else begin
              strb.cntInc = 1'b1;
            end
          end
        end
        StSearch: begin
          if (phase != 2'd2) begin
            if (txReq) begin
              strb.phInc = 1'b1;
            end
          end else if (rxValid) begin
            if (rxBit != idBit) begin
              stNext = StQuiet;
            end else if (idLast) begin
              stNext = StSel;
            end else begin
              strb.cntInc = 1'b1;
              strb.phClr  = 1'b1;
            end
          end
        end
        default: stNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= StQuiet;
    end else begin
      state <= stNext;
    end
  end

  assign selected = (state == StSel);

  // R2
  bus_reset_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (state == StCmd && !selected));

  // R7
  quiet_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == StQuiet && !busReset) |=> (state == StQuiet));

  // R3
  sel_after_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selected) |-> $past(rxValid || txReq));

  // R5
  match_miss_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == StMatch && rxValid && !busReset && rxBit != idBit)
      |=> (!selected && state == StQuiet));

endmodule

// File: rtl/swr_rom_layer.sv
module swr_rom_layer
  import swr_pkg::*;
#(
  parameter int IdBits = 64,
  parameter logic [IdBits-1:0] IdCode = 64'h5E00_0012_3456_7812,
  parameter int SelBits = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busReset,
  input  logic                    rxValid,
  input  logic                    rxBit,
  input  logic                    txReq,
  input  logic [SelBits-1:0]      condSel,
  input  logic [(1<<SelBits)-1:0] evtIn,
  output logic                    txBit,
  output logic                    selected
);

  romState_t          state;
  dpStrobe_t          strb;
  logic [CmdBits-1:0] cmdNext;
  logic               cmdLast;
  logic               idBit;
  logic               idLast;
  logic [1:0]         phase;
  logic               condMet;

  assign condMet = evtIn[condSel];

  swr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReset (busReset),
    .rxValid  (rxValid),
    .rxBit    (rxBit),
    .txReq    (txReq),
    .condMet  (condMet),
    .cmdNext  (cmdNext),
    .cmdLast  (cmdLast),
    .idBit    (idBit),
    .idLast   (idLast),
    .phase    (phase),
    .state    (state),
    .strb     (strb),
    .selected (selected)
  );

  swr_dpath #(
    .IdBits (IdBits),
    .IdCode (IdCode)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .state   (state),
    .rxBit   (rxBit),
    .cmdNext (cmdNext),
    .cmdLast (cmdLast),
    .idBit   (idBit),
    .idLast  (idLast),
    .phase   (phase),
    .txBit   (txBit)
  );

  // R10
  released_when_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> txBit);

endmodule

// File: tb/swr_rom_layer_tb.sv
`timescale 1ns/1ps
module swr_rom_layer_tb;

  localparam int IdBits = 64;
  localparam logic [63:0] IdCode = 64'h5E00_0012_3456_7812;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReset = 1'b0;
  logic        rxValid = 1'b0;
  logic        rxBit = 1'b0;
  logic        txReq = 1'b0;
  logic [4:0]  condSel = '0;
  logic [31:0] evtIn = '0;
  logic        txBit;
  logic        selected;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  swr_rom_layer #(.IdBits(IdBits), .IdCode(IdCode)) u_dut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxBit(rxBit), .txReq(txReq), .condSel(condSel), .evtIn(evtIn),
    .txBit(txBit), .selected(selected)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic busRst();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); rxValid = 1'b1; rxBit = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic readSlot(output logic b);
    @(negedge clk); b = txBit; txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  function automatic logic knownCode(input logic [7:0] v);
    return (v == 8'h33 || v == 8'h55 || v == 8'hF0 || v == 8'hEC || v == 8'hCC);
  endfunction

  task automatic doReadId();
    logic b;
    busRst();
    sendByte(8'h33);
    for (int i = 0; i < IdBits; i++) begin
      readSlot(b);
      check("R4 id bit", b, IdCode[i]);
    end
    check("R4 selected after read", selected, 1'b1);
    readSlot(b);
    check("R10 released when selected", b, 1'b1);
  endtask

  // mm == IdBits means no mismatch
  task automatic doMatch(input int mm);
    logic b;
    busRst();
    sendByte(8'h55);
    readSlot(b);
    check("R10 released during match", b, 1'b1);
    for (int i = 0; i < IdBits; i++) sendBit(IdCode[i] ^ (i == mm));
    check("R5 match result", selected, (mm >= IdBits));
    readSlot(b);
    check("R5 line released after match", b, 1'b1);
  endtask

  task automatic doSearch(input logic [7:0] cmd, input logic part, input int mm);
    logic a, c, dropped;
    busRst();
    sendByte(cmd);
    dropped = !part;
    for (int i = 0; i < IdBits; i++) begin
      readSlot(a);
      readSlot(c);
      if (dropped) begin
        check(part ? "R7 dropped bit" : "R8 ignored bit", a, 1'b1);
        check(part ? "R7 dropped cmpl" : "R8 ignored cmpl", c, 1'b1);
      end else begin
        check("R6 search bit", a, IdCode[i]);
        check("R6 search cmpl", c, ~IdCode[i]);
      end
      sendBit(IdCode[i] ^ (i == mm));
      if (i == mm) dropped = 1'b1;
    end
    check(dropped ? "R7 not selected" : "R6 selected", selected, !dropped);
  endtask

  task automatic doCond(input logic [4:0] sel, input logic [31:0] ev, input int mm);
    condSel = sel;
    evtIn = ev;
    doSearch(8'hEC, ev[sel], mm);
    check("R11 condition index", selected, ev[sel] && (mm >= IdBits));
  endtask

  task automatic doUnknown(input logic [7:0] code);
    logic b;
    busRst();
    sendByte(code);
    check("R9 unknown not selected", selected, 1'b0);
    readSlot(b);
    check("R9 unknown released", b, 1'b1);
    sendByte(8'hCC);
    check("R9 stays quiet", selected, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic b;
    void'($urandom(32'd2406));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset selected", selected, 1'b0);
    check("R1 reset txBit", txBit, 1'b1);

    sendByte(8'hCC);
    check("R1 ignored before bus reset", selected, 1'b0);

    busRst();
    sendByte(8'hCC);
    check("R3 skip selects", selected, 1'b1);
    readSlot(b);
    check("R10 skip released", b, 1'b1);
    busRst();
    check("R2 reset deselects", selected, 1'b0);

    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0); sendBit(1'b0);
    busRst();
    sendByte(8'hCC);
    check("R2 command restarted", selected, 1'b1);

    doReadId();
    doMatch(IdBits);
    doMatch(0);
    doMatch(IdBits - 1);
    doSearch(8'hF0, 1'b1, IdBits);
    doSearch(8'hF0, 1'b1, 0);
    doSearch(8'hF0, 1'b1, IdBits - 1);
    doCond(5'd0, 32'h0000_0001, IdBits);
    doCond(5'd31, 32'h7FFF_FFFF, IdBits);
    doCond(5'd17, 32'h0002_0000, 5);
    doUnknown(8'h00);
    doUnknown(8'hFF);

    // mid-search bus reset
    busRst();
    sendByte(8'hF0);
    readSlot(b);
    busRst();
    sendByte(8'hCC);
    check("R2 reset during search", selected, 1'b1);

    for (int n = 0; n < 30; n++) begin
      int kind;
      int mm;
      logic [7:0] code;
      kind = $urandom_range(0, 5);
      mm = ($urandom_range(0, 1) == 0) ? IdBits : $urandom_range(0, IdBits - 1);
      case (kind)
        0: doReadId();
        1: doMatch(mm);
        2: doSearch(8'hF0, 1'b1, mm);
        3: doCond(5'($urandom_range(0, 31)), $urandom, mm);
        4: begin
          do code = 8'($urandom_range(0, 255)); while (knownCode(code));
          doUnknown(code);
        end
        default: begin
          busRst();
          sendByte(8'hCC);
          check("R3 skip selects", selected, 1'b1);
        end
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule